// File: doc/BRIEF.md
# Per-Module Clock Gating Controller

This block stores a two-bit gating mode for each peripheral module of a chip. It turns those modes, together with the present system power state, into one registered clock-enable per module. The mode fields are packed sixteen to a 32-bit control word, and there are three such words. A writer supplies only a flat module index and a new mode. The block works out which word and which bit pair the index refers to, and it changes that pair alone. A read port returns any control word in full, so software can see the whole gating picture.

The power state comes from a separate sequencer outside this block. Its codes are run, wait and doze. A module can be kept always off, always on, on only while running, or on while running or waiting. The enables feed glitch-free gating cells placed elsewhere.

Top module: `clkgate_ctrl`

## Requirements
- R1: A synchronous active-high reset sets every mode field, including the unused slots, to 3. It drives every `clk_en` bit to 1 and drives `rd_data` to 0.
- R2: Module index `i` sits in control word `i/16`, at bits `2*(i%16)+1 : 2*(i%16)`. Within a word, bit 0 is the least significant bit.
- R3: A module whose mode is 0 has its enable at 0 in every power state.
- R4: A module whose mode is 1 is enabled only when the power state is run.
- R5: A module whose mode is 2 is enabled when the power state is run or wait, and gated when it is doze.
- R6: A module whose mode is 3 has its enable at 1 in every power state.
- R7: `pwr_state` is encoded as 0 for run, 1 for wait and 2 for doze. The unused code 3 is treated like doze.
- R8: A write with a valid index changes only the selected two-bit field. Every other field of every word keeps its value.
- R9: A write whose index is 39 or above changes no field and no enable.
- R10: `clk_en` is registered. A mode written at one clock edge shows on the enable at the following edge. A `pwr_state` change shows at the first edge that samples it.
- R11: `rd_data` is registered. It returns word `rd_sel` one edge after `rd_sel` is sampled, and returns 0 when `rd_sel` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Field update strobe |
| wr_index | input | 6 | Flat module index of the update |
| wr_mode | input | 2 | New gating mode for that module |
| pwr_state | input | 2 | System power state: 0 run, 1 wait, 2 doze |
| rd_sel | input | 2 | Control word to read back |
| rd_data | output | 32 | Registered read-back word |
| clk_en | output | 39 | Registered clock enable per module |

## Verification
The hardest cases to reach are writes that land on neighbouring fields, or on the unused top slots of the last word, while the power state is changing. In those cases a wrong mask or a missed index check alters a field that no enable exposes. The stimulus writes chosen boundary indices (15, 16, 38, 39, 47), then a long pseudo-random run of writes and power-state changes. A behavioural model mirrors every field, and after each clock edge the bench compares all enables and the read-back word against that model.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  localparam int unsigned MODE_W = 2;

  typedef enum logic [1:0] {
    GM_OFF      = 2'd0,
    GM_RUN      = 2'd1,
    GM_RUN_WAIT = 2'd2,
    GM_ALWAYS   = 2'd3
  } gate_mode_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_WAIT = 2'd1,
    PS_DOZE = 2'd2,
    PS_RSVD = 2'd3
  } pwr_state_e;

  // Decide whether a module with the given mode may clock in the given state.
  function automatic logic mode_allows(input logic [1:0] mode, input logic [1:0] ps);
    logic ok;
    case (gate_mode_e'(mode))
      GM_OFF:      ok = 1'b0;
      GM_RUN:      ok = (pwr_state_e'(ps) == PS_RUN);
      GM_RUN_WAIT: ok = (pwr_state_e'(ps) == PS_RUN) || (pwr_state_e'(ps) == PS_WAIT);
      default:     ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cg_index_decode.sv
module cg_index_decode #(
  parameter int unsigned IDX_W          = 6,
  parameter int unsigned FIELDS_PER_REG = 16,
  parameter int unsigned NUM_REGS       = 3,
  parameter int unsigned NUM_MODULES    = 39
) (
  input  logic [IDX_W-1:0]          index,
  output logic                      valid,
  output logic [NUM_REGS-1:0]       reg_hot,
  output logic [FIELDS_PER_REG-1:0] fld_hot
);
  localparam int unsigned FLD_W = $clog2(FIELDS_PER_REG);
  localparam int unsigned RSL_W = IDX_W - FLD_W;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_MODULES);

  assign valid = ({1'b0, index} < LIMIT);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign reg_hot[r] = (index[IDX_W-1:FLD_W] == RSL_W'(r));
  end

  for (genvar f = 0; f < FIELDS_PER_REG; f++) begin : g_fld
    assign fld_hot[f] = (index[FLD_W-1:0] == FLD_W'(f));
  end

endmodule

// File: rtl/cg_field_bank.sv
module cg_field_bank #(
  parameter int unsigned NUM_REGS       = 3,
  parameter int unsigned FIELDS_PER_REG = 16,
  parameter int unsigned SEL_W          = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_go,
  input  logic [NUM_REGS-1:0]                    reg_hot,
  input  logic [FIELDS_PER_REG-1:0]              fld_hot,
  input  logic [clkgate_pkg::MODE_W-1:0]         wr_mode,
  input  logic [SEL_W-1:0]                       rd_sel,
  output logic [FIELDS_PER_REG*clkgate_pkg::MODE_W-1:0] rd_data,
  output logic [NUM_REGS*FIELDS_PER_REG*clkgate_pkg::MODE_W-1:0] words_flat
);
  import clkgate_pkg::*;

  localparam int unsigned REG_W = FIELDS_PER_REG * MODE_W;

  logic [REG_W-1:0] field_mask;
  logic [REG_W-1:0] field_data;
  logic [REG_W-1:0] words [NUM_REGS];

  for (genvar f = 0; f < FIELDS_PER_REG; f++) begin : g_mask
    assign field_mask[f*MODE_W +: MODE_W] = {MODE_W{fld_hot[f]}};
    assign field_data[f*MODE_W +: MODE_W] = wr_mode;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[r] <= '1;
      end else if (wr_go && reg_hot[r]) begin
        words[r] <= (words[r] & ~field_mask) | (field_data & field_mask);
      end
    end
    assign words_flat[r*REG_W +: REG_W] = words[r];
  end

  logic [REG_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_sel == SEL_W'(r)) rd_next = words[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/cg_enable_gen.sv
module cg_enable_gen #(
  parameter int unsigned NUM_MODULES = 39,
  parameter int unsigned TOTAL_BITS  = 96
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TOTAL_BITS-1:0]  words_flat,
  input  logic [1:0]             pwr_state,
  output logic [NUM_MODULES-1:0] clk_en
);
  import clkgate_pkg::*;

  logic [NUM_MODULES-1:0] en_next;

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
    assign en_next[m] = mode_allows(words_flat[m*MODE_W +: MODE_W], pwr_state);
  end

  always_ff @(posedge clk) begin
    if (rst) clk_en <= '1;
    else     clk_en <= en_next;
  end

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int unsigned NUM_MODULES    = 39,
  parameter int unsigned NUM_REGS       = 3,
  parameter int unsigned FIELDS_PER_REG = 16,
  parameter int unsigned IDX_W          = $clog2(NUM_REGS * FIELDS_PER_REG),
  parameter int unsigned SEL_W          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  parameter int unsigned REG_W          = FIELDS_PER_REG * clkgate_pkg::MODE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_index,
  input  logic [1:0]             wr_mode,
  input  logic [1:0]             pwr_state,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [REG_W-1:0]       rd_data,
  output logic [NUM_MODULES-1:0] clk_en
);
  localparam int unsigned TOTAL_BITS = NUM_REGS * REG_W;

  logic                      idx_valid;
  logic [NUM_REGS-1:0]       reg_hot;
  logic [FIELDS_PER_REG-1:0] fld_hot;
  logic [TOTAL_BITS-1:0]     words_flat;

  cg_index_decode #(
    .IDX_W(IDX_W), .FIELDS_PER_REG(FIELDS_PER_REG),
    .NUM_REGS(NUM_REGS), .NUM_MODULES(NUM_MODULES)
  ) u_dec (
    .index(wr_index), .valid(idx_valid), .reg_hot(reg_hot), .fld_hot(fld_hot)
  );

  cg_field_bank #(
    .NUM_REGS(NUM_REGS), .FIELDS_PER_REG(FIELDS_PER_REG), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_go(wr_en && idx_valid), .reg_hot(reg_hot),
    .fld_hot(fld_hot), .wr_mode(wr_mode), .rd_sel(rd_sel), .rd_data(rd_data),
    .words_flat(words_flat)
  );

  cg_enable_gen #(
    .NUM_MODULES(NUM_MODULES), .TOTAL_BITS(TOTAL_BITS)
  ) u_en (
    .clk(clk), .rst(rst), .words_flat(words_flat), .pwr_state(pwr_state),
    .clk_en(clk_en)
  );

endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
  parameter int unsigned NUM_MODULES = 39,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned TOTAL_BITS  = 96
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [IDX_W-1:0]       wr_index,
  input logic [1:0]             pwr_state,
  input logic [NUM_MODULES-1:0] clk_en,
  input logic [TOTAL_BITS-1:0]  words_flat
);
  logic seen_rst = 1'b0;
  logic armed    = 1'b0;

  always_ff @(posedge clk) begin
    seen_rst <= seen_rst | rst;
    armed    <= seen_rst & ~rst;
  end

  AST_BAD_INDEX_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed)
    (wr_en && ({1'b0, wr_index} >= (IDX_W+1)'(NUM_MODULES))) |=> $stable(words_flat)); // R9

  AST_SINGLE_FIELD: assert property (@(posedge clk) disable iff (rst || !armed)
    wr_en |=> ($countones(words_flat ^ $past(words_flat)) <= 2)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed)
    !wr_en |=> $stable(words_flat)); // R8

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_m
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst || !armed)
      (words_flat[2*m +: 2] == 2'd0) |=> !clk_en[m]); // R3
    AST_MODE_RUN: assert property (@(posedge clk) disable iff (rst || !armed)
      (words_flat[2*m +: 2] == 2'd1) |=> (clk_en[m] == ($past(pwr_state) == 2'd0))); // R4
    AST_MODE_RUNWAIT: assert property (@(posedge clk) disable iff (rst || !armed)
      (words_flat[2*m +: 2] == 2'd2) |=> (clk_en[m] == ($past(pwr_state) < 2'd2))); // R5
    AST_MODE_ON: assert property (@(posedge clk) disable iff (rst || !armed)
      (words_flat[2*m +: 2] == 2'd3) |=> clk_en[m]); // R6
  end

endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
  .NUM_MODULES(NUM_MODULES), .IDX_W(IDX_W), .TOTAL_BITS(TOTAL_BITS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index),
  .pwr_state(pwr_state), .clk_en(clk_en), .words_flat(words_flat)
);

// File: tb/tb_clkgate_ctrl.sv
module tb_clkgate_ctrl;
  localparam int NMOD = 39;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_index = '0;
  logic [1:0]  wr_mode = '0;
  logic [1:0]  pwr_state = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [NMOD-1:0] clk_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  clkgate_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index), .wr_mode(wr_mode),
    .pwr_state(pwr_state), .rd_sel(rd_sel), .rd_data(rd_data), .clk_en(clk_en)
  );

  // Behavioural reference model
  int          m_mode [48];
  logic [NMOD-1:0] exp_en;
  logic [31:0] exp_rd;
  bit          live = 0;

  function automatic bit allow(int mode, int ps);
    if (mode == 0) return 0;
    if (mode == 1) return ps == 0;
    if (mode == 2) return ps == 0 || ps == 1;
    return 1;
  endfunction

  function automatic logic [31:0] word_of(int w);
    logic [31:0] v = '0;
    for (int f = 0; f < 16; f++) v[2*f +: 2] = 2'(m_mode[w*16+f]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 48; i++) m_mode[i] = 3;
      exp_en = '1;
      exp_rd = '0;
      live = 1;
    end else if (live) begin
      for (int i = 0; i < NMOD; i++) exp_en[i] = allow(m_mode[i], int'(pwr_state));
      exp_rd = (rd_sel < 2'd3) ? word_of(int'(rd_sel)) : 32'h0;
      if (wr_en && wr_index < 6'd39) m_mode[wr_index] = int'(wr_mode);
    end
    cycles++;
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      for (int i = 0; i < NMOD; i++) begin
        if (clk_en[i] !== exp_en[i]) begin
          case (m_mode[i])
            0: check("R3 enable", 64'(clk_en[i]), 64'(exp_en[i]));
            1: check("R4 enable", 64'(clk_en[i]), 64'(exp_en[i]));
            2: check("R5 enable", 64'(clk_en[i]), 64'(exp_en[i]));
            default: check("R6 enable", 64'(clk_en[i]), 64'(exp_en[i]));
          endcase
        end
      end
      check("R11 readback model", 64'(rd_data), 64'(exp_rd));
    end
  end

  task automatic wr(int idx, int mode);
    @(negedge clk);
    wr_en = 1'b1; wr_index = 6'(idx); wr_mode = 2'(mode);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int sel);
    @(negedge clk);
    rd_sel = 2'(sel);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 clk_en after reset", 64'(clk_en), 64'({NMOD{1'b1}}));
    check("R1 rd_data after reset", 64'(rd_data), 64'h0);
    rst = 1'b0;
    rd(0); check("R1 word0 reset", 64'(rd_data), 64'hFFFF_FFFF);
    rd(2); check("R1 word2 reset", 64'(rd_data), 64'hFFFF_FFFF);

    // R2: index decode
    wr(17, 0); rd(1); check("R2 index17 in word1", 64'(rd_data), 64'hFFFF_FFF3);
    wr(38, 1); rd(2); check("R2 index38 in word2", 64'(rd_data), 64'hFFFF_DFFF);

    // R8: only the addressed field moves
    wr(5, 2); rd(0); check("R8 index5 field", 64'(rd_data), 64'hFFFF_FBFF);
    wr(15, 0); wr(16, 1); rd(0); check("R8 word0 edge", 64'(rd_data), 64'h3FFF_FBFF);
    rd(1); check("R8 word1 edge", 64'(rd_data), 64'hFFFF_FFF1);

    // R9: out-of-range indices ignored
    wr(39, 0); wr(47, 0); wr(63, 1);
    rd(2); check("R9 word2 unchanged", 64'(rd_data), 64'hFFFF_DFFF);
    @(negedge clk);
    check("R9 enables unchanged", 64'(clk_en[38:36]), 64'h7);

    // R3..R7: mode x power-state sweep on modules 0..3
    wr(0, 0); wr(1, 1); wr(2, 2); wr(3, 3);
    pwr_state = 2'd0; @(negedge clk); check("R7 run R3 R4 R5 R6", 64'(clk_en[3:0]), 64'hE);
    pwr_state = 2'd1; @(negedge clk); check("R7 wait R4 R5", 64'(clk_en[3:0]), 64'hC);
    pwr_state = 2'd2; @(negedge clk); check("R7 doze R5 R6", 64'(clk_en[3:0]), 64'h8);
    pwr_state = 2'd3; @(negedge clk); check("R7 code3 as doze", 64'(clk_en[3:0]), 64'h8);
    pwr_state = 2'd0; @(negedge clk);

    // R10: enable latency after a write
    @(negedge clk);
    wr_en = 1'b1; wr_index = 6'd7; wr_mode = 2'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 enable not yet", 64'(clk_en[7]), 64'h1);
    @(negedge clk);
    check("R10 enable after one edge", 64'(clk_en[7]), 64'h0);

    // R11: unused select returns zero
    rd(3); check("R11 select3 zero", 64'(rd_data), 64'h0);

    // Pseudo-random traffic, checked every cycle by the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en     = ($urandom_range(0, 2) != 0);
      wr_index  = 6'($urandom_range(0, 63));
      wr_mode   = 2'($urandom_range(0, 3));
      rd_sel    = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) pwr_state = 2'($urandom_range(0, 3));
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<50000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule